// File: doc/BRIEF.md
# Byte-packing buffer writer

This block turns a stream of 8-, 16-, 24- and 32-bit values into a byte stream and packs it into a circular buffer memory that is 16 bits wide. The buffer holds a continuous run of bytes with no padding between values. A producer presents one value together with a size code over a valid/ready handshake. The block then writes the bytes one per cycle, most significant byte first, through a single word-wide write port.

A byte pointer tracks the next free byte. Bit 0 of the pointer selects the half of the word, and the remaining bits form the word address. A byte at an even position starts a fresh word with the upper half cleared. A byte at an odd position completes that word: the block rewrites it with the new byte on top and the low byte it wrote one position earlier. The block keeps that low byte in a register, so it never has to read the memory back.

The buffer spans a parameterised range of word addresses. After the byte at twice the top word address has been written, the pointer returns to twice the base word address and a one-cycle flush request tells the consumer that the buffer has wrapped.

Top module: `bytepack_writer`

## Requirements
- R1: After reset `in_ready` is 1, `mem_we` and `flush_req` are 0, and `byte_ptr` equals 2*BASE_WORD.
- R2: Size code 0, 1, 2 and 3 selects 1, 2, 3 and 4 bytes, taken from the low 8, 16, 24 and 32 bits of `in_value`; the value bits above the selected size have no effect on any write.
- R3: The bytes of an accepted value are written in consecutive cycles, one per cycle, most significant byte first (for size 2: bits 23:16, then 15:8, then 7:0).
- R4: Every write goes to word address `byte_ptr >> 1`, the byte pointer value before that byte is counted.
- R5: A byte at an even pointer is written as data {8'h00, byte}: the byte in bits 7:0 and bits 15:8 cleared.
- R6: A byte at an odd pointer is written as data {byte, low}: the byte in bits 15:8, and in bits 7:0 the byte most recently written at the even pointer just below it.
- R7: The pointer advances by one per byte written and stays within 2*BASE_WORD to 2*TOP_WORD; after the byte at 2*TOP_WORD it reloads to 2*BASE_WORD.
- R8: `flush_req` is high for exactly one cycle, the cycle after the write of the byte at pointer 2*TOP_WORD, and is low at all other times.
- R9: A value is taken in one handshake cycle; `in_ready` then stays low while more than one of its bytes remains and rises again in the cycle its last byte is written, so an N-byte value holds `in_ready` low for N-1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a value |
| in_ready | output | 1 | Block accepts a value in this cycle |
| in_size | input | 2 | Byte count minus one (0: 8 bits … 3: 32 bits) |
| in_value | input | 32 | Value to pack, right-aligned |
| mem_we | output | 1 | Write strobe to the buffer memory |
| mem_waddr | output | ADDR_W | Word address of the write |
| mem_wdata | output | 16 | Full word written |
| flush_req | output | 1 | One-cycle pulse after the buffer wraps |
| byte_ptr | output | ADDR_W+1 | Next byte position in the buffer |

## Verification
The bench builds the block with ADDR_W = 6, BASE_WORD = 3 and TOP_WORD = 8. This gives a buffer of only eleven byte positions (6 to 16), so wraps occur every few values. Because the span is odd, multi-byte values straddle the wrap point and land on both parities, and a byte pair split across the wrap never merges. Value sizes cycle through all four codes with junk above the selected width. Each emitted word and each flush pulse is compared with a software model of the pointer.

// File: rtl/bpw_pkg.sv
package bpw_pkg;

   localparam int unsigned VAL_W  = 32;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = 2 * BYTE_W;
   localparam int unsigned CNT_W  = $clog2(VAL_W / BYTE_W + 1);

   typedef enum logic [1:0] {
      SZ_B8  = 2'd0,
      SZ_B16 = 2'd1,
      SZ_B24 = 2'd2,
      SZ_B32 = 2'd3
   } bpw_size_e;

   function automatic logic [CNT_W-1:0] bpw_nbytes(input logic [1:0] sz);
      return CNT_W'(sz) + CNT_W'(1);
   endfunction

endpackage

// File: rtl/bpw_seq.sv
module bpw_seq
   import bpw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_size,
   input  logic [VAL_W-1:0]  in_value,
   input  logic              adv,
   output logic              in_ready,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_out
);

   logic [VAL_W-1:0] sreg;
   logic [CNT_W-1:0] left;
   logic             take;
   logic [1:0]       pad;

   assign in_ready   = (left == '0) || ((left == CNT_W'(1)) && adv);
   assign take       = in_valid && in_ready;
   assign byte_valid = (left != '0);
   assign byte_out   = sreg[VAL_W-1 -: BYTE_W];
   assign pad        = 2'd3 - in_size;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         left <= '0;
      end else if (take) begin
         sreg <= in_value << {pad, 3'b000};
         left <= bpw_nbytes(in_size);
      end else if (adv) begin
         sreg <= sreg << BYTE_W;
         left <= left - CNT_W'(1);
      end
   end

   // R9
   busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (in_size != SZ_B8)) |=> !in_ready);

endmodule

// File: rtl/bpw_ptr.sv
module bpw_ptr #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_WORD = 4,
   parameter int unsigned TOP_WORD  = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [ADDR_W:0] ptr,
   output logic          wrap,
   output logic          flush_req
);

   localparam int unsigned PW = ADDR_W + 1;
   localparam logic [PW-1:0] START = PW'(2 * BASE_WORD);
   localparam logic [PW-1:0] LAST  = PW'(2 * TOP_WORD);

   assign wrap = (ptr == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr       <= START;
         flush_req <= 1'b0;
      end else begin
         flush_req <= adv && wrap;
         if (adv) ptr <= wrap ? START : ptr + PW'(1);
      end
   end

   // R7
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr >= START) && (ptr <= LAST));

   // R7
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !wrap) |=> (ptr == $past(ptr) + PW'(1)));

   // R8
   flush_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> (ptr == START));

   // R8
   flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> !flush_req);

endmodule

// File: rtl/bpw_port.sv
module bpw_port
   import bpw_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [ADDR_W:0]   ptr,
   output logic              adv,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [WORD_W-1:0] mem_wdata
);

   logic [BYTE_W-1:0] low_keep;
   logic              odd;

   assign odd       = ptr[0];
   assign adv       = byte_valid;
   assign mem_we    = byte_valid;
   assign mem_waddr = ptr[ADDR_W:1];
   assign mem_wdata = odd ? {byte_in, low_keep} : {{BYTE_W{1'b0}}, byte_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  low_keep <= '0;
      else if (byte_valid && !odd) low_keep <= byte_in;
   end

endmodule

// File: rtl/bytepack_writer.sv
module bytepack_writer
   import bpw_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_WORD = 4,
   parameter int unsigned TOP_WORD  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_size,
   input  logic [31:0]       in_value,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [15:0]       mem_wdata,
   output logic              flush_req,
   output logic [ADDR_W:0]   byte_ptr
);

   if (TOP_WORD <= BASE_WORD) begin : g_bad_span
      $error("bytepack_writer: TOP_WORD must exceed BASE_WORD");
   end
   if (TOP_WORD >= (1 << ADDR_W)) begin : g_bad_top
      $error("bytepack_writer: TOP_WORD does not fit in ADDR_W bits");
   end

   logic              adv;
   logic              wrap;
   logic              byte_valid;
   logic [BYTE_W-1:0] byte_cur;

   bpw_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_size    (in_size),
      .in_value   (in_value),
      .adv        (adv),
      .in_ready   (in_ready),
      .byte_valid (byte_valid),
      .byte_out   (byte_cur)
   );

   bpw_ptr #(
      .ADDR_W    (ADDR_W),
      .BASE_WORD (BASE_WORD),
      .TOP_WORD  (TOP_WORD)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .ptr       (byte_ptr),
      .wrap      (wrap),
      .flush_req (flush_req)
   );

   bpw_port #(
      .ADDR_W (ADDR_W)
   ) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_in    (byte_cur),
      .ptr        (byte_ptr),
      .adv        (adv),
      .mem_we     (mem_we),
      .mem_waddr  (mem_waddr),
      .mem_wdata  (mem_wdata)
   );

   // R8
   flush_only_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !wrap) |=> !flush_req);

endmodule

// File: tb/test_bytepack_writer.sv
module test_bytepack_writer;

   localparam int AW   = 6;
   localparam int BASE = 3;
   localparam int TOP  = 8;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [15:0]   data;
      logic          fl;
      logic          odd;
   } wr_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [1:0]    in_size = 2'd0;
   logic [31:0]   in_value = '0;
   logic          mem_we;
   logic [AW-1:0] mem_waddr;
   logic [15:0]   mem_wdata;
   logic          flush_req;
   logic [AW:0]   byte_ptr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   int mp = 2 * BASE;
   logic [7:0] msh = '0;
   bit fpend = 0;
   wr_t expq[$];

   always #10 clk = ~clk;

   bytepack_writer #(.ADDR_W(AW), .BASE_WORD(BASE), .TOP_WORD(TOP)) i_bytepack_writer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_size(in_size), .in_value(in_value), .mem_we(mem_we),
      .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .flush_req(flush_req),
      .byte_ptr(byte_ptr));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_byte(input logic [7:0] b);
      wr_t e;
      e.addr = AW'(mp >> 1);
      e.odd  = mp[0];
      if (mp % 2 == 0) begin
         e.data = {8'h00, b};
         msh = b;
      end else begin
         e.data = {b, msh};
      end
      e.fl = (mp == 2 * TOP);
      mp = e.fl ? 2 * BASE : mp + 1;
      expq.push_back(e);
   endtask

   task automatic send(input logic [31:0] v, input logic [1:0] sz);
      for (int k = int'(sz); k >= 0; k--) model_byte(v[8*k +: 8]);
      @(negedge clk);
      in_valid = 1'b1;
      in_value = v;
      in_size  = sz;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (8) @(negedge clk);
      check(expq.size() == 0, "R3", expq.size(), 0);
      check(byte_ptr == (AW+1)'(mp), "R7", byte_ptr, mp);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (fpend || flush_req) check(flush_req == fpend, "R8", flush_req, fpend);
         fpend = 0;
         if (mem_we) begin
            if (expq.size() == 0) begin
               check(0, "R3", mem_waddr, 0);
            end else begin
               wr_t e;
               e = expq.pop_front();
               check(mem_waddr == e.addr, "R4", mem_waddr, e.addr);
               if (e.odd) check(mem_wdata == e.data, "R6", mem_wdata, e.data);
               else       check(mem_wdata == e.data, "R5", mem_wdata, e.data);
               fpend = e.fl;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(in_ready == 1'b1, "R1", in_ready, 1);
      check(mem_we == 1'b0, "R1", mem_we, 0);
      check(flush_req == 1'b0, "R1", flush_req, 0);
      check(byte_ptr == (AW+1)'(2*BASE), "R1", byte_ptr, 2*BASE);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: single bytes, junk above bit 7
      send(32'hAABBCC12, 2'd0);
      send(32'hFFFFFF34, 2'd0);
      send(32'h00000056, 2'd0);
      drain();

      // R3: 16, 24, 32 bit values back to back, crossing the wrap
      send(32'hDEAD1234, 2'd1);
      send(32'h77ABCDEF, 2'd2);
      send(32'h89ABCDEF, 2'd3);
      send(32'h01020304, 2'd3);
      drain();

      // R9: ready pattern for a 32-bit value: low 3 cycles, then high
      send(32'hCAFEF00D, 2'd3);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         check(in_ready == (c == 3), "R9", in_ready, (c == 3));
      end
      drain();

      // R9: 8-bit value keeps ready high
      send(32'h12345678, 2'd0);
      @(negedge clk);
      check(in_ready == 1'b1, "R9", in_ready, 1);
      drain();

      // mixed stream, all sizes, several wraps (R7, R8)
      for (int i = 0; i < 60; i++) send(32'h9E3779B9 * (i + 1), 2'(i % 4));
      drain();
      for (int i = 0; i < 23; i++) send(32'h5A5A0000 | i, 2'(3 - (i % 4)));
      drain();

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule